// File: doc/BRIEF.md
# Voltage Regulator Fault Supervisor

This block is the digital protection core of a multiphase regulator controller. Every clock it compares a sampled output-voltage code against the reference (DAC) code. It also watches two supply-good flags, an over-current comparator flag and a soft-start-active flag. From these it decides whether the output is ready, whether the gate drivers may run, and whether every phase must be forced into a discharge clamp.

An output that sits too far below the reference for a qualified time drops the ready flag. An output too far above the reference forces all high-side gates off and all low-side gates on until it falls back. Each new overvoltage event outside soft start is counted. The eighth counted event latches a shutdown, which clears only when the block is disabled. An over-current flag kills the driver enable at once and latches a shutdown until the block is disabled or loses its supply.

All codes are unsigned and use one LSB per millivolt. The margins and the undervoltage qualification time are parameters.

Top module: `vr_fault_supervisor`

## Requirements
- R1: While `vcc_good` is low, `pwm_en` and `ss_en` are low from the next clock edge onward; they rise one edge after `vcc_good` and `en` are both high with no shutdown pending.
- R2: `drive_on` is low from the edge after `vccp_good` falls and returns high one edge after `vccp_good` is high again, provided no shutdown is latched.
- R3: If `dac_code - vout_code > UV_MARGIN` holds on every edge for UV_CYCLES = CLK_HZ/1e6 * UV_TIME_US consecutive edges, `ready` falls on the following edge. Any edge without the condition restarts the count.
- R4: Overvoltage means `vout_code > dac_code + 185` when `mode` = 0, and `vout_code > dac_code + 285` when `mode` = 1. Equality is not an overvoltage.
- R5: One edge after an overvoltage is seen, every bit of `hs_off` and `ls_on` is high and `ready` is low. `ls_on` and `ready` return one edge after the overvoltage ends.
- R6: The eighth counted overvoltage trip raises `shutdown` one edge later. At the same time `pwm_en` and `drive_on` drop and `hs_off` stays all ones. This state holds after the voltage recovers and clears one edge after `en` goes low.
- R7: Overvoltage events that begin while `ss_active` is high are not counted.
- R8: When `oc_flag` is high, `drive_on` is low in that same cycle. A latched fault then keeps `drive_on` low and `shutdown` high after the flag drops.
- R9: The over-current latch clears when `en` or `vcc_good` is low at a clock edge.
- R10: `ready` is high only after a completed soft start (a falling edge of `ss_active` while enabled, which sets an internal done flag one edge earlier) with no fault present. `ss_en` falls once soft start completes.
- R11: An overvoltage held over many cycles counts as a single trip, counted on its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low clears latched faults and trip count |
| mode | input | 1 | 0 = standard overvoltage margin, 1 = alternate margin |
| vout_code | input | CODE_W | Sampled output voltage, 1 mV/LSB |
| dac_code | input | CODE_W | Reference voltage, 1 mV/LSB |
| vcc_good | input | 1 | Controller supply above lockout (hysteresis external) |
| vccp_good | input | 1 | Driver supply above lockout (hysteresis external) |
| oc_flag | input | 1 | Over-current comparator output |
| ss_active | input | 1 | Soft-start ramp in progress |
| ready | output | 1 | Output in regulation |
| drive_on | output | 1 | Gate driver enable |
| hs_off | output | NPHASE | Per-phase force of the high-side gate off |
| ls_on | output | NPHASE | Per-phase force of the low-side gate on |
| pwm_en | output | 1 | PWM generation enable |
| ss_en | output | 1 | Soft-start enable |
| shutdown | output | 1 | Latched shutdown (over-current or trip limit) |

## Verification
Assertions check on every cycle the properties that hold edge by edge. The trip counter never exceeds its limit and never moves while soft start runs or while an overvoltage is held. A latched shutdown persists while enabled. The clamp follows a detected overvoltage, supply loss gates the enables, and `ready` never asserts without soft-start completion. Only the bench scenarios can show the exact window boundaries (185/285 mV equality, a 300 mV gap), the undervoltage delay landing on the precise edge and restarting after one good sample, and the eighth trip being the one that shuts down. They also show the recovery paths through `en` and `vcc_good`.

// File: rtl/vr_sup_pkg.sv
package vr_sup_pkg;

  typedef enum logic {
    OVM_STD = 1'b0,
    OVM_ALT = 1'b1
  } ov_mode_e;

  typedef struct packed {
    logic uv_fault;
    logic ov_now;
    logic ov_sd;
    logic oc_any;
  } fault_vec_t;

endpackage

// File: rtl/vr_sup_window.sv
module vr_sup_window
  import vr_sup_pkg::*;
#(
  parameter int CODE_W        = 12,
  parameter int UV_MARGIN     = 300,
  parameter int OV_MARGIN_STD = 185,
  parameter int OV_MARGIN_ALT = 285
) (
  input  logic [CODE_W-1:0] vout_code,
  input  logic [CODE_W-1:0] dac_code,
  input  ov_mode_e          mode,
  output logic              uv_now,
  output logic              ov_now
);
  localparam int EW = CODE_W + 2;
  localparam logic [EW-1:0] UV_M  = EW'(UV_MARGIN);
  localparam logic [EW-1:0] OV_MS = EW'(OV_MARGIN_STD);
  localparam logic [EW-1:0] OV_MA = EW'(OV_MARGIN_ALT);

  logic [EW-1:0] vo_ext, dac_ext, ov_lim, uv_lim;

  always_comb begin
    vo_ext  = EW'(vout_code);
    dac_ext = EW'(dac_code);
    ov_lim  = dac_ext + ((mode == OVM_ALT) ? OV_MA : OV_MS);
    uv_lim  = vo_ext + UV_M;
    ov_now  = vo_ext > ov_lim;
    uv_now  = uv_lim < dac_ext;
  end
endmodule

// File: rtl/vr_sup_uv_timer.sv
module vr_sup_uv_timer #(
  parameter int LIMIT = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic uv_now,
  output logic uv_fault
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || !uv_now) cnt_q <= '0;
    else if (cnt_q != LIM)      cnt_q <= cnt_q + 1'b1;
  end

  assign uv_fault = (cnt_q == LIM);

  AST_UV_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM); // R3
  AST_UV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !uv_now |=> !uv_fault); // R3
endmodule

// File: rtl/vr_sup_ov_tracker.sv
module vr_sup_ov_tracker #(
  parameter int TRIP_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ov_now,
  input  logic ss_active,
  output logic ov_sd
);
  localparam int TW = $clog2(TRIP_LIMIT + 1);
  localparam logic [TW-1:0] TLIM = TW'(TRIP_LIMIT);

  logic [TW-1:0] trips_q;
  logic          ov_prev_q;
  logic          new_trip;

  assign new_trip = ov_now && !ov_prev_q && !ss_active && (trips_q != TLIM);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      trips_q   <= '0;
      ov_prev_q <= 1'b0;
    end else begin
      ov_prev_q <= ov_now;
      if (new_trip) trips_q <= trips_q + 1'b1;
    end
  end

  assign ov_sd = (trips_q == TLIM);

  AST_TRIP_SAT: assert property (@(posedge clk) disable iff (rst)
    trips_q <= TLIM); // R6
  AST_SD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ov_sd && run) |=> ov_sd); // R6
  AST_SS_NOCOUNT: assert property (@(posedge clk) disable iff (rst)
    (ss_active && run) |=> (trips_q == $past(trips_q))); // R7
  AST_ONE_PER_EVENT: assert property (@(posedge clk) disable iff (rst)
    (run && ov_now && ov_prev_q) |=> (trips_q == $past(trips_q)) || (trips_q == '0)); // R11
endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
  import vr_sup_pkg::*;
#(
  parameter int CODE_W        = 12,
  parameter int NPHASE        = 4,
  parameter int CLK_HZ        = 100_000_000,
  parameter int UV_TIME_US    = 5000,
  parameter int UV_MARGIN     = 300,
  parameter int OV_MARGIN_STD = 185,
  parameter int OV_MARGIN_ALT = 285,
  parameter int TRIP_LIMIT    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mode,
  input  logic [CODE_W-1:0] vout_code,
  input  logic [CODE_W-1:0] dac_code,
  input  logic              vcc_good,
  input  logic              vccp_good,
  input  logic              oc_flag,
  input  logic              ss_active,
  output logic              ready,
  output logic              drive_on,
  output logic [NPHASE-1:0] hs_off,
  output logic [NPHASE-1:0] ls_on,
  output logic              pwm_en,
  output logic              ss_en,
  output logic              shutdown
);
  localparam int UV_CYCLES = (CLK_HZ / 1_000_000) * UV_TIME_US;

  logic       run;
  logic       uv_now, ov_now, uv_fault, ov_sd;
  logic       ss_act_d, ss_done_q, oc_lat_q;
  logic       drv_q, ready_q, pwm_q, ssen_q, sd_q;
  logic       sd_any;
  fault_vec_t fv;

  assign run = en && vcc_good;

  vr_sup_window #(
    .CODE_W(CODE_W), .UV_MARGIN(UV_MARGIN),
    .OV_MARGIN_STD(OV_MARGIN_STD), .OV_MARGIN_ALT(OV_MARGIN_ALT)
  ) u_window (
    .vout_code(vout_code), .dac_code(dac_code), .mode(ov_mode_e'(mode)),
    .uv_now(uv_now), .ov_now(ov_now)
  );

  vr_sup_uv_timer #(.LIMIT(UV_CYCLES)) u_uv (
    .clk(clk), .rst(rst), .run(run), .uv_now(uv_now), .uv_fault(uv_fault)
  );

  vr_sup_ov_tracker #(.TRIP_LIMIT(TRIP_LIMIT)) u_ov (
    .clk(clk), .rst(rst), .run(run), .ov_now(ov_now),
    .ss_active(ss_active), .ov_sd(ov_sd)
  );

  always_comb begin
    fv.uv_fault = uv_fault;
    fv.ov_now   = ov_now;
    fv.ov_sd    = ov_sd;
    fv.oc_any   = oc_lat_q || oc_flag;
    sd_any      = fv.oc_any || fv.ov_sd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_act_d  <= 1'b0;
      ss_done_q <= 1'b0;
      oc_lat_q  <= 1'b0;
      drv_q     <= 1'b0;
      ready_q   <= 1'b0;
      pwm_q     <= 1'b0;
      ssen_q    <= 1'b0;
      sd_q      <= 1'b0;
    end else begin
      ss_act_d  <= run && ss_active;
      ss_done_q <= run && (ss_done_q || (ss_act_d && !ss_active));
      oc_lat_q  <= run && (oc_lat_q || oc_flag);
      drv_q     <= run && vccp_good && !sd_any;
      pwm_q     <= run && !sd_any;
      ssen_q    <= run && !sd_any && !ss_done_q;
      sd_q      <= run && sd_any;
      ready_q   <= run && vccp_good && ss_done_q && !fv.uv_fault
                   && !fv.ov_now && !sd_any;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NPHASE; gi++) begin : g_phase
      logic hs_q, ls_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          hs_q <= 1'b0;
          ls_q <= 1'b0;
        end else begin
          hs_q <= ov_now || ov_sd;
          ls_q <= ov_now;
        end
      end
      assign hs_off[gi] = hs_q;
      assign ls_on[gi]  = ls_q;
    end
  endgenerate

  assign ready    = ready_q;
  assign drive_on = drv_q && !oc_flag;
  assign pwm_en   = pwm_q;
  assign ss_en    = ssen_q;
  assign shutdown = sd_q;

  AST_VCC_GATE: assert property (@(posedge clk) disable iff (rst)
    !vcc_good |=> (!pwm_en && !ss_en)); // R1
  AST_OC_LATCHED: assert property (@(posedge clk) disable iff (rst)
    ($past(oc_flag) && run) |-> !drive_on); // R8
  AST_OV_CLAMP: assert property (@(posedge clk) disable iff (rst)
    ov_now |=> ((&hs_off) && (&ls_on) && !ready)); // R5
  AST_READY_SS: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(ss_done_q)); // R10
endmodule

// File: tb/vr_fault_supervisor_test.sv
module vr_fault_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 12;
  localparam int NPH = 4;
  localparam int UVC = 50;

  logic clk = 1'b0;
  logic rst, en, mode, vcc_good, vccp_good, oc_flag, ss_active;
  logic [CW-1:0] vout_code, dac_code;
  logic ready, drive_on, pwm_en, ss_en, shutdown;
  logic [NPH-1:0] hs_off, ls_on;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vr_fault_supervisor #(
    .CODE_W(CW), .NPHASE(NPH), .CLK_HZ(1_000_000), .UV_TIME_US(UVC)
  ) uut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .vout_code(vout_code),
    .dac_code(dac_code), .vcc_good(vcc_good), .vccp_good(vccp_good),
    .oc_flag(oc_flag), .ss_active(ss_active), .ready(ready),
    .drive_on(drive_on), .hs_off(hs_off), .ls_on(ls_on), .pwm_en(pwm_en),
    .ss_en(ss_en), .shutdown(shutdown)
  );

  typedef struct packed {
    logic          md;
    logic [CW-1:0] vo;
    logic          clamp;
    logic          rdy;
  } vec_t;

  // dac fixed at 1000 mV; window edges for both margins and the UV gap
  localparam vec_t VECS [9] = '{
    '{1'b0, 12'd1000, 1'b0, 1'b1},
    '{1'b0, 12'd1185, 1'b0, 1'b1},
    '{1'b0, 12'd1186, 1'b1, 1'b0},
    '{1'b1, 12'd1186, 1'b0, 1'b1},
    '{1'b1, 12'd1285, 1'b0, 1'b1},
    '{1'b1, 12'd1286, 1'b1, 1'b0},
    '{1'b0, 12'd700,  1'b0, 1'b1},
    '{1'b0, 12'd699,  1'b0, 1'b1},
    '{1'b0, 12'd1000, 1'b0, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bring_up();
    en = 1'b0;
    step(2);
    en = 1'b1;
    ss_active = 1'b1;
    step(3);
    ss_active = 1'b0;
    step(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL R0 watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b1; mode = 1'b0; vcc_good = 1'b0; vccp_good = 1'b1;
    oc_flag = 1'b0; ss_active = 1'b0; vout_code = 12'd1000; dac_code = 12'd1000;
    step(3);
    chk("reset", "ready", 32'(ready), 0);
    chk("reset", "drive_on", 32'(drive_on), 0);
    chk("reset", "shutdown", 32'(shutdown), 0);
    chk("reset", "ls_on", 32'(ls_on), 0);
    rst = 1'b0;

    // R1: supply lockout holds enables low
    step(2);
    chk("R1", "pwm_en vcc low", 32'(pwm_en), 0);
    chk("R1", "ss_en vcc low", 32'(ss_en), 0);
    vcc_good = 1'b1;
    step(1);
    chk("R1", "pwm_en vcc good", 32'(pwm_en), 1);
    chk("R1", "ss_en vcc good", 32'(ss_en), 1);

    // R10: no ready before soft start completes
    chk("R10", "ready before ss", 32'(ready), 0);
    ss_active = 1'b1;
    step(2);
    chk("R10", "ready during ss", 32'(ready), 0);
    ss_active = 1'b0;
    step(2);
    chk("R10", "ready after ss", 32'(ready), 1);
    chk("R10", "ss_en after ss", 32'(ss_en), 0);

    // R2: driver supply lockout
    vccp_good = 1'b0;
    step(1);
    chk("R2", "drive_on vccp low", 32'(drive_on), 0);
    vccp_good = 1'b1;
    step(1);
    chk("R2", "drive_on vccp back", 32'(drive_on), 1);

    // R4/R5: window table
    foreach (VECS[i]) begin
      mode = VECS[i].md;
      vout_code = VECS[i].vo;
      step(2);
      chk("R4", $sformatf("vec%0d ls_on", i), 32'(ls_on), 32'({NPH{VECS[i].clamp}}));
      chk("R5", $sformatf("vec%0d hs_off", i), 32'(hs_off), 32'({NPH{VECS[i].clamp}}));
      chk("R5", $sformatf("vec%0d ready", i), 32'(ready), 32'(VECS[i].rdy));
    end
    mode = 1'b0;

    // R3: undervoltage qualification, exact edge
    vout_code = 12'd600;
    step(UVC);
    chk("R3", "ready at limit", 32'(ready), 1);
    step(1);
    chk("R3", "ready past limit", 32'(ready), 0);
    vout_code = 12'd1000;
    step(2);
    chk("R3", "ready recovered", 32'(ready), 1);
    vout_code = 12'd600;
    step(UVC - 1);
    vout_code = 12'd1000;
    step(1);
    vout_code = 12'd600;
    step(UVC - 1);
    chk("R3", "ready after interrupted uv", 32'(ready), 1);
    vout_code = 12'd1000;
    step(2);

    // R7: trips during soft start are not counted
    en = 1'b0;
    step(2);
    en = 1'b1;
    ss_active = 1'b1;
    step(1);
    for (int k = 0; k < 10; k++) begin
      vout_code = 12'd1300; step(1);
      vout_code = 12'd1000; step(1);
    end
    ss_active = 1'b0;
    step(3);
    chk("R7", "shutdown after ss trips", 32'(shutdown), 0);
    chk("R7", "ready after ss trips", 32'(ready), 1);

    // R11: long events count once; seven trips leave it running
    for (int k = 0; k < 7; k++) begin
      vout_code = 12'd1300; step(4);
      vout_code = 12'd1000; step(1);
    end
    step(1);
    chk("R11", "shutdown after 7 trips", 32'(shutdown), 0);
    chk("R11", "pwm_en after 7 trips", 32'(pwm_en), 1);

    // R6: eighth trip latches shutdown
    vout_code = 12'd1300;
    step(3);
    chk("R6", "shutdown 8th trip", 32'(shutdown), 1);
    chk("R6", "pwm_en 8th trip", 32'(pwm_en), 0);
    chk("R6", "drive_on 8th trip", 32'(drive_on), 0);
    vout_code = 12'd1000;
    step(2);
    chk("R6", "shutdown held", 32'(shutdown), 1);
    chk("R6", "hs_off held", 32'(hs_off), 32'({NPH{1'b1}}));
    chk("R5", "ls_on released", 32'(ls_on), 0);
    en = 1'b0;
    step(1);
    chk("R6", "shutdown cleared by en", 32'(shutdown), 0);
    bring_up();
    chk("R6", "ready after restart", 32'(ready), 1);

    // R8: over-current drops drive at once and latches
    oc_flag = 1'b1;
    #1;
    chk("R8", "drive_on same cycle", 32'(drive_on), 0);
    step(1);
    oc_flag = 1'b0;
    step(2);
    chk("R8", "drive_on latched", 32'(drive_on), 0);
    chk("R8", "shutdown latched", 32'(shutdown), 1);

    // R9: enable toggle clears the latch
    en = 1'b0;
    step(1);
    en = 1'b1;
    step(2);
    chk("R9", "drive_on after en toggle", 32'(drive_on), 1);
    chk("R9", "shutdown after en toggle", 32'(shutdown), 0);

    // R9: supply loss clears the latch
    oc_flag = 1'b1;
    step(1);
    oc_flag = 1'b0;
    step(1);
    chk("R8", "drive_on latched again", 32'(drive_on), 0);
    vcc_good = 1'b0;
    step(1);
    vcc_good = 1'b1;
    step(2);
    chk("R9", "drive_on after vcc cycle", 32'(drive_on), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule